// File: doc/BRIEF.md
# Charge Pump Speed-Up Controller

This block sits between the decoded control bits of a PLL synthesizer and the current-select inputs of its three charge pumps: the main proportional pump, the main integral pump and the auxiliary pump. Its outputs are current multipliers. To keep the one-and-a-half step of the auxiliary pump exact, every multiplier is given in half-units of the bias current.

The block tracks which register word was loaded last. When the serial-load strobe rises after a main-divider word, the pumps enter a high-current speed-up state. That state lasts exactly as long as the strobe stays high, so the strobe width sets the speed-up time. A strobe that follows any other word leaves the pumps in normal mode. Two override bits can hold speed-up on continuously or block it completely. A gain bit scales every current down by three, and a second bit switches the integral pump off.

Everything runs on one clock. The strobe is sampled synchronously, so speed-up starts on the clock edge after the strobe is seen high and ends on the edge after it is seen low.

Top module: `cp_boost_ctrl`

## Requirements
- R1: After reset, `speed_up_o` is 0. The arming flag is clear, so a strobe that comes before any word load produces no speed-up.
- R2: `aux_mult_o` is 3 half-units when `low_gain_i`=0 and 1 half-unit when `low_gain_i`=1. Speed-up does not change it.
- R3: `prop_mult_o` is 6 (normal) or 30 (speed-up) half-units when `low_gain_i`=0. It is 2 or 10 half-units when `low_gain_i`=1.
- R4: `integ_mult_o` is 72 (`low_gain_i`=0) or 24 (`low_gain_i`=1) half-units during speed-up. It is 0 whenever `integ_off_i`=1 or speed-up is inactive.
- R5: A load with `ld_main_i`=1 arms the block. On each clock edge where the block is armed and the strobe is sampled high, `speed_up_o` is 1 after that edge. It returns to 0 on the edge after the strobe is sampled low.
- R6: A load with `ld_main_i`=0 disarms the block. A strobe that follows it leaves `speed_up_o` at 0.
- R7: With `force_boost_i`=1 and `block_boost_i`=0, `speed_up_o` is 1 from the next clock edge, whatever the strobe does.
- R8: With `block_boost_i`=1, `speed_up_o` is 0 from the next clock edge, even when `force_boost_i`=1.
- R9: When the strobe falls and no load occurs on that cycle, the block disarms. A second strobe with no new main-divider load produces no speed-up.
- R10: A load on a cycle sets or clears the arming flag according to `ld_main_i`, even when the strobe falls on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid_i | input | 1 | One-cycle pulse: a register word has just been loaded |
| ld_main_i | input | 1 | With `ld_valid_i`: 1 if the loaded word is the main-divider word |
| strobe_i | input | 1 | Serial-load strobe |
| force_boost_i | input | 1 | Hold speed-up on continuously |
| block_boost_i | input | 1 | Prevent speed-up (has priority over force) |
| low_gain_i | input | 1 | 1 selects the one-third current set |
| integ_off_i | input | 1 | 1 switches the integral pump off |
| speed_up_o | output | 1 | Speed-up state active |
| prop_mult_o | output | MULT_W | Proportional pump current, half-units |
| integ_mult_o | output | MULT_W | Integral pump current, half-units |
| aux_mult_o | output | MULT_W | Auxiliary pump current, half-units |

## Verification
The bench builds the block with its default parameters: 7-bit multipliers, high-gain levels 6, 30, 72 and 3 half-units, and a low-gain divisor of 3. These values cover the largest code, 72, and every low-gain result. Random traffic of loads, strobes of varied width and slow-changing override bits drives the arming flag through all of its transitions, including loads that coincide with a strobe fall. Directed cases pin down the exact edge on which speed-up starts and ends, and the priority of the block bit over the force bit.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  // Levels for the high-gain set, in half-units of the bias current.
  localparam int unsigned PROP_NORM_DEF  = 6;
  localparam int unsigned PROP_BOOST_DEF = 30;
  localparam int unsigned INTEG_BOOST_DEF = 72;
  localparam int unsigned AUX_DEF        = 3;
  localparam int unsigned LOW_DIV_DEF    = 3;

  typedef struct packed {
    logic force_on;
    logic block;
  } boost_ovr_t;
endpackage

// File: rtl/cpb_arm.sv
module cpb_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_valid_i,
  input  logic ld_main_i,
  input  logic strobe_i,
  output logic armed_o
);
  logic strobe_q;
  logic armed_d;
  logic strobe_fall;

  assign strobe_fall = strobe_q && !strobe_i;

  always_comb begin
    armed_d = armed_o;
    if (ld_valid_i)       armed_d = ld_main_i;
    else if (strobe_fall) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed_o  <= 1'b0;
    end else begin
      strobe_q <= strobe_i;
      armed_o  <= armed_d;
    end
  end

  // R6: a load of any other word disarms
  p_other_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && !ld_main_i) |=> !armed_o);
  // R10: a main-word load arms, even when the strobe falls on that cycle
  p_main_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && ld_main_i) |=> armed_o);
  // R9: a strobe fall with no load consumes the arming
  p_consume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !strobe_i && !ld_valid_i) |=> !armed_o);
endmodule

// File: rtl/cpb_mode.sv
module cpb_mode
  import cpb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed_i,
  input  logic       strobe_i,
  input  boost_ovr_t ovr_i,
  output logic       boost_o
);
  logic boost_d;

  always_comb begin
    if (ovr_i.block)         boost_d = 1'b0;
    else if (ovr_i.force_on) boost_d = 1'b1;
    else                     boost_d = armed_i && strobe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boost_o <= 1'b0;
    else        boost_o <= boost_d;
  end

  // R8: the block bit dominates
  p_block_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_i.block |=> !boost_o);
  // R7: force holds speed-up on
  p_force_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_i.force_on && !ovr_i.block) |=> boost_o);
  // R5/R6: without arming or force there is no speed-up
  p_need_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_i && !ovr_i.force_on) |=> !boost_o);
  // R5: speed-up ends after the strobe is sampled low
  p_strobe_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !ovr_i.force_on) |=> !boost_o);
endmodule

// File: rtl/cpb_gain.sv
module cpb_gain #(
  parameter int unsigned MULT_W      = 7,
  parameter int unsigned PROP_NORM   = 6,
  parameter int unsigned PROP_BOOST  = 30,
  parameter int unsigned INTEG_BOOST = 72,
  parameter int unsigned AUX_LVL     = 3,
  parameter int unsigned LOW_DIV     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boost_i,
  input  logic              low_gain_i,
  input  logic              integ_off_i,
  output logic [MULT_W-1:0] prop_o,
  output logic [MULT_W-1:0] integ_o,
  output logic [MULT_W-1:0] aux_o
);
  localparam int NLVL = 4;
  localparam int unsigned HI_LVL [NLVL] = '{PROP_NORM, PROP_BOOST, INTEG_BOOST, AUX_LVL};

  // Each level has a full and a one-third version; pick per gain bit.
  logic [MULT_W-1:0] lvl [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam logic [MULT_W-1:0] FULL  = MULT_W'(HI_LVL[g]);
    localparam logic [MULT_W-1:0] SCALE = MULT_W'(HI_LVL[g] / LOW_DIV);
    assign lvl[g] = low_gain_i ? SCALE : FULL;
  end

  always_comb begin
    prop_o  = boost_i ? lvl[1] : lvl[0];
    integ_o = (boost_i && !integ_off_i) ? lvl[2] : '0;
    aux_o   = lvl[3];
  end

  // R4: integral pump silent when off or not boosting
  p_integ_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_off_i || !boost_i) |-> (integ_o == '0));
  // R2: auxiliary level does not depend on speed-up
  p_aux_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(low_gain_i) |-> $stable(aux_o));
endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl
  import cpb_pkg::*;
#(
  parameter int unsigned MULT_W      = 7,
  parameter int unsigned PROP_NORM   = PROP_NORM_DEF,
  parameter int unsigned PROP_BOOST  = PROP_BOOST_DEF,
  parameter int unsigned INTEG_BOOST = INTEG_BOOST_DEF,
  parameter int unsigned AUX_LVL     = AUX_DEF,
  parameter int unsigned LOW_DIV     = LOW_DIV_DEF,
  parameter int unsigned RST_SYNC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic              ld_main_i,
  input  logic              strobe_i,
  input  logic              force_boost_i,
  input  logic              block_boost_i,
  input  logic              low_gain_i,
  input  logic              integ_off_i,
  output logic              speed_up_o,
  output logic [MULT_W-1:0] prop_mult_o,
  output logic [MULT_W-1:0] integ_mult_o,
  output logic [MULT_W-1:0] aux_mult_o
);
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_s_n;
  logic                armed;
  boost_ovr_t          ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[RST_SYNC-1];

  assign ovr.force_on = force_boost_i;
  assign ovr.block    = block_boost_i;

  cpb_arm u_arm (
    .clk(clk), .rst_n(rst_s_n), .ld_valid_i(ld_valid_i),
    .ld_main_i(ld_main_i), .strobe_i(strobe_i), .armed_o(armed)
  );

  cpb_mode u_mode (
    .clk(clk), .rst_n(rst_s_n), .armed_i(armed), .strobe_i(strobe_i),
    .ovr_i(ovr), .boost_o(speed_up_o)
  );

  cpb_gain #(
    .MULT_W(MULT_W), .PROP_NORM(PROP_NORM), .PROP_BOOST(PROP_BOOST),
    .INTEG_BOOST(INTEG_BOOST), .AUX_LVL(AUX_LVL), .LOW_DIV(LOW_DIV)
  ) u_gain (
    .clk(clk), .rst_n(rst_s_n), .boost_i(speed_up_o), .low_gain_i(low_gain_i),
    .integ_off_i(integ_off_i), .prop_o(prop_mult_o), .integ_o(integ_mult_o),
    .aux_o(aux_mult_o)
  );

  // R1: the block is idle while the synchronized reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_s_n |-> !speed_up_o);
endmodule

// File: tb/cp_boost_ctrl_tb_top.sv
module cp_boost_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_v = 1'b0, ld_m = 1'b0, strb = 1'b0, frc = 1'b0, blk = 1'b0, lg = 1'b0, ioff = 1'b0;
  logic su;
  logic [MW-1:0] prop, integ, aux;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference state, built from the requirements
  logic m_arm = 1'b0, m_boost = 1'b0, m_sprev = 1'b0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_boost_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_v), .ld_main_i(ld_m), .strobe_i(strb),
    .force_boost_i(frc), .block_boost_i(blk), .low_gain_i(lg), .integ_off_i(ioff),
    .speed_up_o(su), .prop_mult_o(prop), .integ_mult_o(integ), .aux_mult_o(aux)
  );

  always @(posedge clk) begin
    if (model_on) begin
      if (ld_v)                  m_arm <= ld_m;            // R6, R10
      else if (m_sprev && !strb) m_arm <= 1'b0;            // R9
      m_boost <= blk ? 1'b0 : (frc ? 1'b1 : (strb && m_arm)); // R5, R7, R8
      m_sprev <= strb;
    end
  end

  function automatic int e_prop(bit b, bit l);
    return l ? (b ? 10 : 2) : (b ? 30 : 6);
  endfunction
  function automatic int e_integ(bit b, bit l, bit off);
    return (!b || off) ? 0 : (l ? 24 : 72);
  endfunction
  function automatic int e_aux(bit l);
    return l ? 1 : 3;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string ctx);
    chk(int'(su), int'(m_boost), {ctx, " R5 speed_up"});
    chk(int'(prop), e_prop(m_boost, lg), {ctx, " R3 prop"});
    chk(int'(integ), e_integ(m_boost, lg, ioff), {ctx, " R4 integ"});
    chk(int'(aux), e_aux(lg), {ctx, " R2 aux"});
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(bit main);
    ld_v = 1'b1; ld_m = main; step(); ld_v = 1'b0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) step();
    chk(int'(su), 0, "R1 speed_up in reset");
    rst_n = 1'b1;
    repeat (4) step();
    model_on = 1;
    chk(int'(su), 0, "R1 speed_up after reset");
    // R1: strobe before any load
    strb = 1'b1; step(); chk(int'(su), 0, "R1 unarmed strobe");
    strb = 1'b0; step();

    // R5: main word then strobe; exact start and end edges
    load(1'b1);
    strb = 1'b1; step();
    chk(int'(su), 1, "R5 rise after strobe");
    chk(int'(integ), 72, "R4 integ boost full gain");
    chk(int'(prop), 30, "R3 prop boost full gain");
    step(); step(); chk(int'(su), 1, "R5 held while strobe high");
    strb = 1'b0; step();
    chk(int'(su), 0, "R5 fall after strobe low");
    chk(int'(prop), 6, "R3 prop normal");
    // R9: second strobe without a new main word
    strb = 1'b1; step(); chk(int'(su), 0, "R9 re-strobe no boost");
    strb = 1'b0; step();

    // R6: other word then strobe
    load(1'b1); load(1'b0);
    strb = 1'b1; step(); chk(int'(su), 0, "R6 other word strobe");
    strb = 1'b0; step();

    // R10: main load on the same cycle as a strobe fall keeps the arm
    load(1'b1);
    strb = 1'b1; step();
    strb = 1'b0; ld_v = 1'b1; ld_m = 1'b1; step(); ld_v = 1'b0;
    chk(int'(su), 0, "R10 boost ends at fall");
    strb = 1'b1; step(); chk(int'(su), 1, "R10 still armed");
    strb = 1'b0; step();

    // R7 / R8 / low gain / integral off
    lg = 1'b1; frc = 1'b1; step();
    chk(int'(su), 1, "R7 force on");
    chk(int'(integ), 24, "R4 integ boost low gain");
    chk(int'(prop), 10, "R3 prop boost low gain");
    chk(int'(aux), 1, "R2 aux low gain");
    ioff = 1'b1; step(); chk(int'(integ), 0, "R4 integ off");
    blk = 1'b1; step(); chk(int'(su), 0, "R8 block over force");
    blk = 1'b0; frc = 1'b0; ioff = 1'b0; lg = 1'b0; step();
    chk(int'(aux), 3, "R2 aux full gain");

    // Random traffic checked against the reference state
    for (int i = 0; i < 5000; i++) begin
      ld_v = ($urandom % 4) == 0;
      ld_m = $urandom % 2;
      if (($urandom % 3) == 0) strb = ~strb;
      if (($urandom % 40) == 0) frc = ~frc;
      if (($urandom % 50) == 0) blk = ~blk;
      if (($urandom % 30) == 0) lg = ~lg;
      if (($urandom % 30) == 0) ioff = ~ioff;
      step();
      chk_all("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule